// File: doc/BRIEF.md
# Dual-Mode Serial Shift and Event Counter Port

This block holds a 4-bit data register that serves one of two roles, chosen by bit 0 of a 4-bit enable register. In shift mode the register moves one place toward its MSB on every instruction-cycle strobe, taking the serial input into bit 0, and the serial output can present the MSB. In counter mode the register counts down by one for every falling edge on the serial input. An edge counts only after the input has been seen at the new level on two consecutive strobes. A controller can swap the register with its accumulator at any clock. The same swap copies a carry bit into a clock-output latch, and that latch drives the clock pin. Bit 2 of the enable register gates the output drivers of an 8-bit port. Bit 1 has no function.

The input edge filter is a four-state machine. LVL_HIGH moves to LVL_FALLING on a low sample. LVL_FALLING returns to LVL_HIGH on a high sample, or moves to LVL_LOW once the low level has lasted the required number of samples, and that move raises the count event. LVL_LOW moves to LVL_RISING on a high sample. LVL_RISING falls back to LVL_LOW on a low sample, or reaches LVL_HIGH once the high level has lasted. The register mode is MODE_SHIFT or MODE_COUNT.

Top module: `shift_count_port`

## Requirements
- R1: After reset the enable register and the data register are zero, `port_oe` and `ser_out` are 0, and the clock latch is 1, so `clk_pin` equals `cyc_stb` (one sync pulse per instruction cycle).
- R2: With enable bit 0 clear, each clock edge with `cyc_stb` high loads `{par_val[2:0], ser_in}` into the register.
- R3: With enable bit 0 clear, `ser_out` equals `par_val[3]` when enable bit 3 is 1, and is 0 when enable bit 3 is 0.
- R4: With enable bit 0 set, the register decrements by one at the strobe edge that takes the second consecutive low sample of `ser_in` after the filter has accepted a high level.
- R5: In counter mode a decrement from 0 gives 15.
- R6: A low level seen on only one strobe sample causes no decrement, and a low level that lasts does not decrement again.
- R7: With enable bit 0 set, `ser_out` equals enable bit 3.
- R8: A clock edge with `xchg_req` high loads `xchg_data` into the register and `carry_in` into the clock latch. This overrides a shift or a count at the same edge, and `par_val` shows the old value until that edge.
- R9: `clk_pin` equals the latch ANDed with `cyc_stb` in shift mode, and equals the latch in counter mode.
- R10: `port_oe` equals enable bit 2. Enable bit 1 affects no output.
- R11: A clock edge with `en_load` high loads all four bits of `en_data` into the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock wide |
| ser_in | input | 1 | Serial data in, or count input |
| en_load | input | 1 | Load the enable register |
| en_data | input | 4 | New enable value (bit 0 mode, bit 2 port drive, bit 3 serial-out) |
| xchg_req | input | 1 | Exchange with accumulator |
| xchg_data | input | 4 | Accumulator value to load |
| carry_in | input | 1 | Carry bit copied into the clock latch on exchange |
| ser_out | output | 1 | Serial output |
| clk_pin | output | 1 | Clock pin |
| par_val | output | 4 | Current register value |
| port_oe | output | 1 | Output-driver enable of the 8-bit port |

## Verification
An exchange can fall in the same cycle as a shift strobe or as a completed count edge. The bench provokes this with directed cases: it raises `xchg_req` on the strobe that shifts, and on the strobe that takes the second low sample. Random stimulus that mixes exchanges, strobes and runs of input levels then brings up many more such collisions. A reference model in the bench gives the exchange priority, so the register must hold exactly `xchg_data` after that edge, and the next strobe must shift or count from that loaded value.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        LVL_HIGH,
        LVL_FALLING,
        LVL_LOW,
        LVL_RISING
    } lvl_state_t;

    typedef enum logic {
        MODE_SHIFT,
        MODE_COUNT
    } sio_mode_t;

    localparam int EN_W        = 4;
    localparam int EN_MODE_BIT = 0;
    localparam int EN_PORT_BIT = 2;
    localparam int EN_SO_BIT   = 3;
endpackage

// File: rtl/sio_edge_filter.sv
module sio_edge_filter
    import sio_pkg::*;
#(
    parameter int STABLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic ser_in,
    output logic fall_evt
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    lvl_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic cnt_last;

    assign cnt_last = (cnt_q == CW'(STABLE_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        fall_evt = 1'b0;
        if (cyc_stb) begin
            unique case (state_q)
                LVL_HIGH: begin
                    if (!ser_in) begin
                        state_d = LVL_FALLING;
                        cnt_d   = CW'(1);
                    end
                end
                LVL_FALLING: begin
                    if (ser_in) begin
                        state_d = LVL_HIGH;
                        cnt_d   = '0;
                    end else if (cnt_last) begin
                        state_d  = LVL_LOW;
                        cnt_d    = '0;
                        fall_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                LVL_LOW: begin
                    if (ser_in) begin
                        state_d = LVL_RISING;
                        cnt_d   = CW'(1);
                    end
                end
                LVL_RISING: begin
                    if (!ser_in) begin
                        state_d = LVL_LOW;
                        cnt_d   = '0;
                    end else if (cnt_last) begin
                        state_d = LVL_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = LVL_HIGH;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // R6
    evt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);

    // R4
    evt_low_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> (cyc_stb && !ser_in));
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
    import sio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sio_mode_t    mode,
    input  logic         cyc_stb,
    input  logic         ser_in,
    input  logic         fall_evt,
    input  logic         xchg_req,
    input  logic [W-1:0] xchg_data,
    input  logic         carry_in,
    output logic [W-1:0] val_q,
    output logic         latch_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= '0;
            latch_q <= 1'b1;
        end else if (xchg_req) begin
            val_q   <= xchg_data;
            latch_q <= carry_in;
        end else begin
            unique case (mode)
                MODE_SHIFT: if (cyc_stb)  val_q <= {val_q[W-2:0], ser_in};
                MODE_COUNT: if (fall_evt) val_q <= val_q - 1'b1;
                default:    val_q <= val_q;
            endcase
        end
    end

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHIFT && cyc_stb && !xchg_req)
        |=> val_q == {$past(val_q[W-2:0]), $past(ser_in)});

    // R5
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT && fall_evt && !xchg_req && val_q == '0)
        |=> val_q == '1);

    // R8
    xchg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_req |=> (val_q == $past(xchg_data) && latch_q == $past(carry_in)));
endmodule

// File: rtl/sio_pin_mux.sv
module sio_pin_mux
    import sio_pkg::*;
(
    input  sio_mode_t mode,
    input  logic      en_so,
    input  logic      en_port,
    input  logic      latch_q,
    input  logic      cyc_stb,
    input  logic      msb,
    output logic      ser_out,
    output logic      clk_pin,
    output logic      port_oe
);
    always_comb begin
        port_oe = en_port;
        unique case (mode)
            MODE_SHIFT: begin
                ser_out = en_so & msb;
                clk_pin = latch_q & cyc_stb;
            end
            MODE_COUNT: begin
                ser_out = en_so;
                clk_pin = latch_q;
            end
            default: begin
                ser_out = 1'b0;
                clk_pin = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shift_count_port.sv
module shift_count_port
    import sio_pkg::*;
#(
    parameter int W          = 4,
    parameter int STABLE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_stb,
    input  logic          ser_in,
    input  logic          en_load,
    input  logic [EN_W-1:0] en_data,
    input  logic          xchg_req,
    input  logic [W-1:0]  xchg_data,
    input  logic          carry_in,
    output logic          ser_out,
    output logic          clk_pin,
    output logic [W-1:0]  par_val,
    output logic          port_oe
);
    logic [EN_W-1:0] en_q;
    sio_mode_t       mode;
    logic            fall_evt;
    logic            latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_load) en_q <= en_data;
    end

    assign mode = en_q[EN_MODE_BIT] ? MODE_COUNT : MODE_SHIFT;

    sio_edge_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_stb  (cyc_stb),
        .ser_in   (ser_in),
        .fall_evt (fall_evt)
    );

    sio_shift_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cyc_stb   (cyc_stb),
        .ser_in    (ser_in),
        .fall_evt  (fall_evt),
        .xchg_req  (xchg_req),
        .xchg_data (xchg_data),
        .carry_in  (carry_in),
        .val_q     (par_val),
        .latch_q   (latch_q)
    );

    sio_pin_mux u_pins (
        .mode    (mode),
        .en_so   (en_q[EN_SO_BIT]),
        .en_port (en_q[EN_PORT_BIT]),
        .latch_q (latch_q),
        .cyc_stb (cyc_stb),
        .msb     (par_val[W-1]),
        .ser_out (ser_out),
        .clk_pin (clk_pin),
        .port_oe (port_oe)
    );

    // R11
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_load |=> (port_oe == $past(en_data[EN_PORT_BIT])));

    // R7
    count_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_load && en_data[EN_MODE_BIT]) |=> ser_out == $past(en_data[EN_SO_BIT]));

    // R3
    shift_so_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_load && !en_data[EN_MODE_BIT] && !en_data[EN_SO_BIT]) |=> !ser_out);

    // R4
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT && fall_evt && !xchg_req && !en_load && par_val != '0)
        |=> par_val == W'($past(par_val) - 1'b1));
endmodule

// File: tb/shift_count_port_tb.sv
`timescale 1ns/1ps
module shift_count_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, ser_in = 1'b1, en_load = 1'b0, xchg_req = 1'b0, carry_in = 1'b0;
    logic [3:0] en_data = '0, xchg_data = '0;
    logic ser_out, clk_pin, port_oe;
    logic [3:0] par_val;

    int n_chk = 0;
    int n_err = 0;

    logic [3:0] m_val, m_en;
    logic       m_latch;
    int         m_fst;

    always #2.5 clk = ~clk;

    shift_count_port u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ser_in(ser_in),
        .en_load(en_load), .en_data(en_data), .xchg_req(xchg_req),
        .xchg_data(xchg_data), .carry_in(carry_in), .ser_out(ser_out),
        .clk_pin(clk_pin), .par_val(par_val), .port_oe(port_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_so();
        return m_en[0] ? m_en[3] : (m_en[3] & m_val[3]);
    endfunction

    function automatic logic exp_clk(input logic stb);
        return m_latch & (m_en[0] | stb);
    endfunction

    task automatic step(input bit stb, input bit si, input bit enl, input logic [3:0] ed,
                        input bit xr, input logic [3:0] xd, input bit cy);
        bit fire;
        @(negedge clk);
        cyc_stb = stb; ser_in = si; en_load = enl; en_data = ed;
        xchg_req = xr; xchg_data = xd; carry_in = cy;
        #1;
        chk(par_val == m_val, "R2/R4/R8 par_val", par_val, m_val);
        chk(ser_out == exp_so(), "R3/R7 ser_out", ser_out, exp_so());
        chk(clk_pin == exp_clk(stb), "R9 clk_pin", clk_pin, exp_clk(stb));
        chk(port_oe == m_en[2], "R10 port_oe", port_oe, m_en[2]);
        fire = 1'b0;
        if (stb) begin
            case (m_fst)
                0: if (!si) m_fst = 1;
                1: if (si) m_fst = 0; else begin m_fst = 2; fire = 1'b1; end
                2: if (si) m_fst = 3;
                default: m_fst = si ? 0 : 2;
            endcase
        end
        if (xr) begin
            m_val = xd; m_latch = cy;
        end else if (!m_en[0]) begin
            if (stb) m_val = {m_val[2:0], si};
        end else if (fire) begin
            m_val = m_val - 4'd1;
        end
        if (enl) m_en = ed;
    endtask

    task automatic peek(input logic [3:0] exp_val, input string tag);
        @(posedge clk);
        #1;
        chk(par_val == exp_val, tag, par_val, exp_val);
    endtask

    initial begin
        #(2_000_000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        m_val = '0; m_en = '0; m_latch = 1'b1; m_fst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(par_val == 4'd0, "R1 par_val", par_val, 0);
        chk(port_oe == 1'b0, "R1 port_oe", port_oe, 0);
        chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        chk(clk_pin == 1'b1, "R1 sync pulse high", clk_pin, 1);
        step(0, 1, 0, 0, 0, 0, 0);
        chk(clk_pin == 1'b0, "R1 sync pulse low", clk_pin, 0);

        // R8: exchange wins over shift in same cycle
        step(1, 1, 0, 0, 1, 4'hA, 0);
        peek(4'hA, "R8 exchange beats shift");
        step(1, 0, 0, 0, 0, 0, 0);
        peek(4'h4, "R2 shift from loaded value");

        // R3: serial out shows MSB with bit3 set
        step(0, 1, 1, 4'b1000, 1, 4'h8, 1);
        step(0, 1, 0, 0, 0, 0, 0);
        chk(ser_out == 1'b1, "R3 ser_out msb", ser_out, 1);

        // R7, R5, R6: counter mode
        step(0, 1, 1, 4'b1001, 1, 4'h0, 1);
        step(1, 1, 0, 0, 0, 0, 0);
        chk(ser_out == 1'b1, "R7 ser_out follows bit3", ser_out, 1);
        chk(clk_pin == 1'b1, "R9 count clk_pin latch", clk_pin, 1);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        peek(4'hF, "R5 wrap 0 to 15");
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        peek(4'hF, "R6 held low no recount");
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        peek(4'hF, "R6 one-sample glitch ignored");
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 4'h6, 0);
        peek(4'h6, "R8 exchange beats count");
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        peek(4'h5, "R4 count from loaded value");

        // R10, R11: bit1 inert, bit2 drives port
        step(0, 1, 1, 4'b0010, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        chk(port_oe == 1'b0, "R10 bit1 no port", port_oe, 0);
        chk(ser_out == 1'b0, "R10 bit1 no ser_out", ser_out, 0);
        step(0, 1, 1, 4'b0100, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        chk(port_oe == 1'b1, "R11 port_oe loaded", port_oe, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit si_r;
            si_r = (($urandom % 4) == 0) ? ~ser_in : ser_in;
            step(($urandom % 2) == 0, si_r, ($urandom % 16) == 0, 4'($urandom),
                 ($urandom % 8) == 0, 4'($urandom), ($urandom % 2) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule